// File: doc/BRIEF.md
# Pulse-Swallow Programmable Divider

This block divides a fast input clock by a programmable ratio N = 32·M + S. It pairs a dual-modulus stage, which divides by 33 or by 32, with a 10-bit main counter M and a 5-bit swallow counter S. In every output cycle the stage runs S periods of 33 input clocks, then M − S periods of 32 input clocks. It emits a single-clock-wide pulse once per N input clocks. That pulse serves as the comparison clock of a phase detector. A fixed divide-by-8 stage placed ahead of this block gives an overall ratio of 8·(32·M + S). With a 6.25 kHz reference, this places the oscillator at 50 kHz × (32·M + S).

The ratio inputs are sampled only at the boundary between output cycles, so a change on them never shortens or stretches a period already in progress. M values below 32 are outside the legal range. Such a value is forced to 32, and a range-error flag is raised for the output cycle that uses it.

Top module: `pulse_swallow_div`

## Requirements
- R1: While rst_ni is low, div_pulse_o, mod_sel_o and range_err_o are 0. The block then runs with M = 32 and S = 0, so the first pulse appears in the 1024th clock cycle, counting the cycle in which rst_ni rises as cycle 1.
- R2: For 32 ≤ M ≤ 1023 and 0 ≤ S ≤ 31, consecutive rising pulses on div_pulse_o are exactly 32·M + S clock cycles apart.
- R3: div_pulse_o is high for exactly one clock cycle per output cycle.
- R4: mod_sel_o (1 = divide by 33) is high for exactly 33·S clock cycles in each output cycle, all at its start. It is never high when S = 0.
- R5: main_ratio_i and swallow_i are sampled only at the clock edge that ends a cycle with div_pulse_o high. Changes at any other time do not alter the current interval.
- R6: A sampled M below 32 is used as 32, giving an interval of 1024 + S cycles. range_err_o is 1 from the cycle after such a sample until the next sample. It is 0 after a sample with M ≥ 32.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Input clock to be divided |
| rst_ni | input | 1 | Active-low synchronous reset |
| main_ratio_i | input | 10 | Main counter value M |
| swallow_i | input | 5 | Swallow counter value S |
| div_pulse_o | output | 1 | One-cycle pulse per N input cycles |
| mod_sel_o | output | 1 | Modulus select of the dual-modulus stage, 1 = divide by 33 |
| range_err_o | output | 1 | Set when the sampled M was below the legal minimum |

## Verification
Each new ratio becomes due one full interval after the pulse whose closing edge samples it. The bench therefore drives the next ratio only after that sampling edge has passed. It then counts clock cycles from one pulse to the next, and during that count it scrambles the inputs before setting the values for the following interval. The modulus-select count and the range flag are sampled over the same interval; the flag is read at the closing pulse, one full interval after the edge that set it. After reset the bench counts cycles from the cycle of release and expects the first pulse in cycle 1024. All samples are taken on the falling clock edge.

// File: rtl/psd_pkg.sv
`timescale 1ns/1ps
package psd_pkg;
  // Force a main-counter value into the legal range.
  function automatic int psd_clamp_main(input int m, input int m_min);
    return (m < m_min) ? m_min : m;
  endfunction

  // Total ratio: base periods of length base plus swallowed extra cycles.
  function automatic int psd_ratio(input int m, input int s, input int base);
    return base * m + s;
  endfunction
endpackage

// File: rtl/psd_ratio_loader.sv
`timescale 1ns/1ps
module psd_ratio_loader #(
  parameter int M_W   = 10,
  parameter int S_W   = 5,
  parameter int M_MIN = 32
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           load_i,
  input  logic [M_W-1:0] m_i,
  input  logic [S_W-1:0] s_i,
  output logic [M_W-1:0] m_eff_o,
  output logic [S_W-1:0] s_eff_o,
  output logic           range_err_o
);
  import psd_pkg::*;

  logic m_low;

  always_comb begin
    m_low   = int'(m_i) < M_MIN;
    m_eff_o = M_W'(psd_clamp_main(int'(m_i), M_MIN));
    s_eff_o = s_i;
  end

  always_ff @(posedge clk_i) begin
    if (!rst_ni)     range_err_o <= 1'b0;
    else if (load_i) range_err_o <= m_low;
  end

  AST_ERR_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> $stable(range_err_o)); // R6
endmodule

// File: rtl/psd_dual_mod.sv
`timescale 1ns/1ps
module psd_dual_mod #(
  parameter int S_W = 5
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic mod33_i,
  output logic tc_o
);
  localparam int BASE  = 1 << S_W;
  localparam int PRE_W = S_W + 1;

  logic [PRE_W-1:0] pc_q;
  logic [PRE_W-1:0] last_cnt;

  always_comb begin
    last_cnt = mod33_i ? PRE_W'(BASE) : PRE_W'(BASE - 1);
    tc_o     = (pc_q == last_cnt);
  end

  always_ff @(posedge clk_i) begin
    if (!rst_ni)   pc_q <= '0;
    else if (tc_o) pc_q <= '0;
    else           pc_q <= pc_q + 1'b1;
  end

  AST_PRE_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pc_q <= PRE_W'(BASE)); // R4
  AST_MOD_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pc_q != '0) |-> $stable(mod33_i)); // R4
endmodule

// File: rtl/psd_period_ctr.sv
`timescale 1ns/1ps
module psd_period_ctr #(
  parameter int M_W   = 10,
  parameter int S_W   = 5,
  parameter int M_MIN = 32
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           tc_i,
  input  logic [M_W-1:0] m_eff_i,
  input  logic [S_W-1:0] s_eff_i,
  output logic           mod33_o,
  output logic           last_o
);
  logic [M_W-1:0] m_rem_q;
  logic [S_W-1:0] s_rem_q;
  logic           final_period;

  always_comb begin
    mod33_o      = (s_rem_q != '0);
    final_period = (m_rem_q == M_W'(1));
    last_o       = tc_i && final_period;
  end

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      m_rem_q <= M_W'(M_MIN);
      s_rem_q <= '0;
    end else if (tc_i) begin
      if (final_period) begin
        m_rem_q <= m_eff_i;
        s_rem_q <= s_eff_i;
      end else begin
        m_rem_q <= m_rem_q - 1'b1;
        if (mod33_o) s_rem_q <= s_rem_q - 1'b1;
      end
    end
  end

  AST_M_NONZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    m_rem_q != '0); // R2
  AST_S_BELOW_M: assert property (@(posedge clk_i) disable iff (!rst_ni)
    M_W'(s_rem_q) < m_rem_q); // R4
  AST_PULSE_ONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    last_o |=> !last_o); // R3
endmodule

// File: rtl/pulse_swallow_div.sv
`timescale 1ns/1ps
module pulse_swallow_div #(
  parameter int M_W   = 10,
  parameter int S_W   = 5,
  parameter int M_MIN = 32
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic [M_W-1:0] main_ratio_i,
  input  logic [S_W-1:0] swallow_i,
  output logic           div_pulse_o,
  output logic           mod_sel_o,
  output logic           range_err_o
);
  logic [M_W-1:0] m_eff;
  logic [S_W-1:0] s_eff;
  logic           pre_tc;
  logic           mod33;
  logic           cycle_end;

  psd_ratio_loader #(.M_W(M_W), .S_W(S_W), .M_MIN(M_MIN)) loader_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(cycle_end),
    .m_i(main_ratio_i), .s_i(swallow_i),
    .m_eff_o(m_eff), .s_eff_o(s_eff), .range_err_o(range_err_o)
  );

  psd_dual_mod #(.S_W(S_W)) presc_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .mod33_i(mod33), .tc_o(pre_tc)
  );

  psd_period_ctr #(.M_W(M_W), .S_W(S_W), .M_MIN(M_MIN)) period_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .tc_i(pre_tc),
    .m_eff_i(m_eff), .s_eff_i(s_eff),
    .mod33_o(mod33), .last_o(cycle_end)
  );

  assign div_pulse_o = cycle_end;
  assign mod_sel_o   = mod33;

  AST_MOD_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cycle_end && swallow_i != '0) |=> mod_sel_o); // R4
  AST_NO_MOD_S0: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cycle_end && swallow_i == '0) |=> !mod_sel_o); // R4
endmodule

// File: tb/pulse_swallow_div_tb_top.sv
`timescale 1ns/1ps
module pulse_swallow_div_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [9:0] m_in = 10'd32;
  logic [4:0] s_in = 5'd0;
  logic       pulse, mod_sel, err;
  int         n_run = 0, n_fail = 0;
  bit         done = 1'b0;

  always #2.5 clk = ~clk;

  pulse_swallow_div dut_i (
    .clk_i(clk), .rst_ni(rst_n), .main_ratio_i(m_in), .swallow_i(s_in),
    .div_pulse_o(pulse), .mod_sel_o(mod_sel), .range_err_o(err)
  );

  localparam int NV = 7;
  localparam int VM [NV] = '{32, 1023, 32, 100, 517, 40, 33};
  localparam int VS [NV] = '{0,  31,   31, 5,   17,  0,  1};

  // Expected interval: M below 32 counts as 32, each unit is 32 cycles.
  function automatic int exp_len(input int m, input int s);
    int mm;
    mm = (m < 32) ? 32 : m;
    return (mm << 5) + s;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Called at a falling edge where the pulse is high; that pulse sampled (m,s).
  task automatic measure(input int m, input int s, input int nm, input int ns);
    int n, modc;
    n = 0; modc = 0;
    @(negedge clk); n = 1;
    check(pulse == 1'b0, "R3 pulse width", pulse, 0);
    m_in = 10'd0; s_in = 5'd31;               // scrambled, must be ignored (R5)
    forever begin
      if (mod_sel) modc++;
      if (pulse || n > 40000) break;
      if (n == 100) begin m_in = 10'(nm); s_in = 5'(ns); end
      @(negedge clk); n++;
    end
    check(n == exp_len(m, s), "R2/R5 interval", n, exp_len(m, s));
    check(modc == 33 * s, "R4 mod_sel count", modc, 33 * s);
    check(err == (m < 32), "R6 range_err", err, (m < 32) ? 1 : 0);
  endtask

  // Release reset at a falling edge and expect the first pulse in cycle 1024 (R1).
  task automatic release_and_first();
    int n;
    rst_n = 1'b1; n = 1;
    check(pulse == 1'b0 && mod_sel == 1'b0, "R1 idle after release", pulse, 0);
    while (!pulse && n < 3000) begin @(negedge clk); n++; end
    check(n == 1024, "R1 first pulse cycle", n, 1024);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    m_in = 10'(VM[0]); s_in = 5'(VS[0]);
    repeat (3) @(negedge clk);
    check(pulse == 0, "R1 reset pulse", pulse, 0);
    check(mod_sel == 0, "R1 reset mod_sel", mod_sel, 0);
    check(err == 0, "R1 reset range_err", err, 0);
    release_and_first();
    for (int i = 0; i < NV; i++) begin
      if (i + 1 < NV) measure(VM[i], VS[i], VM[i+1], VS[i+1]);
      else            measure(VM[i], VS[i], 5, 3);
    end
    measure(5, 3, 0, 0);                       // R6 clamp
    measure(0, 0, 0, 0);                       // R6 clamp from zero
    repeat (50) @(negedge clk);
    check(err == 1, "R6 flag held mid-interval", err, 1);
    rst_n = 1'b0; m_in = 10'd40; s_in = 5'd2;
    repeat (3) @(negedge clk);
    check(err == 0 && pulse == 0 && mod_sel == 0, "R1 mid-run reset", err, 0);
    release_and_first();
    measure(40, 2, 40, 2);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule